// File: doc/BRIEF.md
# Cascadable Dual Compare-Match Timer

This block contains two 8-bit up-counters. Each counter has its own compare register. Each counter advances on ticks from a shared free-running prescaler of the system clock. When a running counter sits at its compare value and a tick arrives, the counter returns to zero and pulses its interrupt line for one cycle. It then keeps counting. The period is therefore (compare + 1) prescaled ticks.

Timer 1 has one source code that makes it count Timer 0 match events instead of prescaler ticks. In that mode the pair acts as one 16-bit timer. Timer 0 forms the low stage and Timer 1 forms the high stage.

Software reaches the block over a byte-wide register bus. The bus exposes one mode register and two data addresses. Reading a data address returns that timer's live count. Writing a data address loads only its compare value and leaves the counter untouched.

Top module: `cmt_pair`

## Requirements
- R1: After a synchronous reset, both counters are 0, the mode register reads 0x00, and both interrupt outputs are low.
- R2: Timer 0 period. The mode register sits at 0xD0 with this layout: bit 6 = timer 1 go, bits 5:4 = timer 1 source, bit 3 = timer 0 go, bit 2 = timer 0 keep, bits 1:0 = timer 0 source. Timer 0 source codes 0, 1, 2 and 3 give tick rates of clk/4, clk/16, clk/64 and clk/256. With compare C, irq0 pulses every (C+1)·divisor cycles.
- R3: Timer 1 source codes 1, 2 and 3 give tick rates of clk/4, clk/16 and clk/64. With compare C, irq1 pulses every (C+1)·divisor cycles.
- R4: Timer 1 source code 0 makes Timer 1 advance once per Timer 0 match. irq1 then pulses every (C0+1)·(C1+1)·divisor0 cycles, and always in the same cycle as an irq0 pulse.
- R5: A read of 0xD2 (timer 0) or 0xD3 (timer 1) returns that counter's value. A write to either address changes only the compare value; the counter reads the same value before and after the write.
- R6: A mode write with a go bit set to 1 clears that counter at the write edge. The clear wins over a coincident tick. The counter then runs.
- R7: When timer 0 has go = 0 and keep = 0, it holds its value across prescaler ticks. When timer 1 has go = 0, it also holds. When timer 0 has keep = 1, it resumes from the held value without clearing.
- R8: The mode register reads back its seven used bits. Bit 7 always reads 0.
- R9: Each interrupt output is high for exactly one cycle per match.
- R10: A compare value of 0 keeps the counter at 0. The interrupt then pulses on every prescaled tick.
- R11: bus_rdata is registered and reflects the address presented one cycle earlier. Unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the previous cycle's address |
| irq0 | output | 1 | Timer 0 match pulse |
| irq1 | output | 1 | Timer 1 match pulse |

## Verification
In cascade mode, a Timer 1 match can only happen in the same cycle as a Timer 0 match. Both interrupts rise together, and Timer 0's wrap doubles as Timer 1's tick. The bench provokes this by giving both timers small compare values in cascade mode. It checks three things: the irq1 spacing equals the product of the two stage periods; irq0 is high at every irq1 pulse; and each pulse lasts one cycle. A second collision is a go-bit write that lands on a tick. The clear must win, and this is judged by reading the counter back as 0 right after the write.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  // decoded view of the seven used mode bits
  typedef struct packed {
    logic       t1_go;
    logic [1:0] t1_src;
    logic       t0_go;
    logic       t0_keep;
    logic [1:0] t0_src;
  } mode_t;

  localparam int MODE_BITS = $bits(mode_t);
  localparam int NUM_T     = 2;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int NUM_TAPS = 4,
  parameter int STEP     = 2
) (
  input  logic                clk,
  input  logic                rst,
  output logic [NUM_TAPS-1:0] tap
);
  localparam int PS_W = NUM_TAPS * STEP;

  logic [PS_W-1:0] ps_q;

  always_ff @(posedge clk) begin
    if (rst) ps_q <= '0;
    else     ps_q <= ps_q + 1'b1;
  end

  // tap i fires once every 2^((i+1)*STEP) cycles
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    assign tap[i] = &ps_q[(i+1)*STEP-1:0];
  end

  assert_tap_single_R2: assert property (@(posedge clk) disable iff (rst)
    tap[0] |=> !tap[0]);
endmodule

// File: rtl/cmt_unit.sv
module cmt_unit #(
  parameter int             W       = 8,
  parameter logic [W-1:0]   CMP_RST = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         run,
  input  logic         tick,
  input  logic         cmp_we,
  input  logic [W-1:0] cmp_wdata,
  output logic [W-1:0] cnt,
  output logic         match,
  output logic         irq
);
  logic [W-1:0] cmp_q;

  assign match = run && tick && !clr && (cnt == cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      cmp_q <= CMP_RST;
      irq   <= 1'b0;
    end else begin
      irq <= match;
      if (cmp_we) cmp_q <= cmp_wdata;
      if (clr)                cnt <= '0;
      else if (run && tick)   cnt <= (cnt == cmp_q) ? '0 : cnt + 1'b1;
    end
  end

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt == '0);
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!clr && !run) |=> $stable(cnt));
  assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    match |=> (cnt == '0) && irq);
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !clr && !match) |=> cnt == $past(cnt) + 1'b1);
  assert_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
endmodule

// File: rtl/cmt_pair.sv
module cmt_pair #(
  parameter int            DW        = 8,
  parameter int            AW        = 8,
  parameter logic [AW-1:0] MODE_ADDR = 8'hD0,
  parameter logic [AW-1:0] DATA_BASE = 8'hD2,
  parameter int            STEP      = 2,
  parameter int            NUM_TAPS  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq0,
  output logic          irq1
);
  import cmt_pkg::*;

  localparam logic [DW-1:0] MODE_MASK = DW'((1 << MODE_BITS) - 1);

  logic [NUM_TAPS-1:0]           tap;
  logic [DW-1:0]                 mode_raw;
  mode_t                         mode;
  mode_t                         wmode;
  logic                          mode_wr;
  logic [NUM_T-1:0]              clr_v, run_v, tick_v, we_v, match_v, irq_v;
  logic [NUM_T-1:0][DW-1:0]      cnt_v;
  logic [NUM_T-1:0]              addr_hit;
  logic                          any_hit;

  cmt_prescaler #(.NUM_TAPS(NUM_TAPS), .STEP(STEP)) u_ps (
    .clk (clk),
    .rst (rst),
    .tap (tap)
  );

  // mode register
  assign mode    = mode_t'(mode_raw[MODE_BITS-1:0]);
  assign wmode   = mode_t'(bus_wdata[MODE_BITS-1:0]);
  assign mode_wr = bus_wr && (bus_addr == MODE_ADDR);

  always_ff @(posedge clk) begin
    if (rst)          mode_raw <= '0;
    else if (mode_wr) mode_raw <= bus_wdata & MODE_MASK;
  end

  // per-timer control
  assign clr_v[0]  = mode_wr && wmode.t0_go;
  assign clr_v[1]  = mode_wr && wmode.t1_go;
  assign run_v[0]  = mode.t0_go || mode.t0_keep;
  assign run_v[1]  = mode.t1_go;
  assign tick_v[0] = tap[mode.t0_src];
  assign tick_v[1] = (mode.t1_src == 2'd0) ? match_v[0] : tap[mode.t1_src - 2'd1];

  for (genvar i = 0; i < NUM_T; i++) begin : g_tmr
    assign addr_hit[i] = (bus_addr == DATA_BASE + AW'(i));
    assign we_v[i]     = bus_wr && addr_hit[i];

    cmt_unit #(.W(DW)) u_unit (
      .clk       (clk),
      .rst       (rst),
      .clr       (clr_v[i]),
      .run       (run_v[i]),
      .tick      (tick_v[i]),
      .cmp_we    (we_v[i]),
      .cmp_wdata (bus_wdata),
      .cnt       (cnt_v[i]),
      .match     (match_v[i]),
      .irq       (irq_v[i])
    );
  end

  assign any_hit = (|addr_hit) || (bus_addr == MODE_ADDR);

  // registered read mux
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
      if (bus_addr == MODE_ADDR) bus_rdata <= mode_raw;
      for (int i = 0; i < NUM_T; i++)
        if (addr_hit[i]) bus_rdata <= cnt_v[i];
    end
  end

  assign irq0 = irq_v[0];
  assign irq1 = irq_v[1];

  assert_cascade_R4: assert property (@(posedge clk) disable iff (rst)
    (irq_v[1] && ($past(mode.t1_src) == 2'd0)) |-> irq_v[0]);
  assert_unmapped_R11: assert property (@(posedge clk) disable iff (rst)
    !any_hit |=> bus_rdata == '0);
  assert_topbit_R8: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> mode_raw[DW-1:MODE_BITS] == '0);
endmodule

// File: tb/sim_cmt_pair.sv
module sim_cmt_pair;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq0, irq1;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  localparam logic [7:0] A_MODE = 8'hD0;
  localparam logic [7:0] A_D0   = 8'hD2;
  localparam logic [7:0] A_D1   = 8'hD3;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cmt_pair u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq0(irq0), .irq1(irq1)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; bus_addr = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk); bus_addr = a;
    @(negedge clk); v = int'(bus_rdata);
    bus_addr = 8'h00;
  endtask

  task automatic wait_irq(input int idx, output int t);
    t = -1;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if ((idx == 0 && irq0) || (idx == 1 && irq1)) begin t = cyc; break; end
    end
  endtask

  // period between two consecutive pulses, also checks one-cycle width (R9)
  task automatic period(input int idx, output int p);
    int t1, t2;
    wait_irq(idx, t1);
    @(negedge clk);
    check(idx == 0 ? !irq0 : !irq1, "R9 pulse width", 1, 0);
    wait_irq(idx, t2);
    p = (t1 < 0 || t2 < 0) ? -1 : t2 - t1;
  endtask

  task automatic t_reset;
    int v;
    check(!irq0 && !irq1, "R1 irq low", int'(irq0) + int'(irq1), 0);
    rd(A_MODE, v); check(v == 0, "R1 mode", v, 0);
    rd(A_D0, v);   check(v == 0, "R1 cnt0", v, 0);
    rd(A_D1, v);   check(v == 0, "R1 cnt1", v, 0);
  endtask

  task automatic t_modereg;
    int v;
    wr(A_MODE, 8'hFF);
    rd(A_MODE, v); check(v == 8'h7F, "R8 mode readback", v, 8'h7F);
    wr(A_MODE, 8'h00);
    rd(8'hD1, v); check(v == 0, "R11 unmapped", v, 0);
  endtask

  task automatic t_t0(input int src, input int cmp, input int div);
    int p;
    wr(A_MODE, 8'h00);
    wr(A_D0, 8'(cmp));
    wr(A_MODE, 8'(8'h08 | src));
    period(0, p);
    check(p == (cmp + 1) * div, "R2 timer0 period", p, (cmp + 1) * div);
    wr(A_MODE, 8'h00);
  endtask

  task automatic t_t1(input int src, input int cmp, input int div);
    int p;
    wr(A_MODE, 8'h00);
    wr(A_D1, 8'(cmp));
    wr(A_MODE, 8'(8'h40 | (src << 4)));
    period(1, p);
    check(p == (cmp + 1) * div, "R3 timer1 period", p, (cmp + 1) * div);
    wr(A_MODE, 8'h00);
  endtask

  task automatic t_cascade;
    int p, t;
    wr(A_MODE, 8'h00);
    wr(A_D0, 8'd2);
    wr(A_D1, 8'd3);
    wr(A_MODE, 8'h48);           // both go, t1 src 0, t0 src 0 (clk/4)
    period(1, p);
    check(p == 3 * 4 * 4, "R4 cascade period", p, 48);
    wait_irq(1, t);
    check(irq0 == 1'b1, "R4 irq0 with irq1", int'(irq0), 1);
    wr(A_MODE, 8'h00);
  endtask

  task automatic t_zero_cmp;
    int p, v;
    wr(A_D0, 8'd0);
    wr(A_MODE, 8'h08);
    period(0, p);
    check(p == 4, "R10 compare zero period", p, 4);
    rd(A_D0, v); check(v == 0, "R10 count stays 0", v, 0);
    wr(A_MODE, 8'h00);
  endtask

  task automatic t_hold_and_data;
    int v1, v2, v3, v4;
    wr(A_D0, 8'hFF);
    wr(A_MODE, 8'h08);
    repeat (40) @(negedge clk);
    wr(A_MODE, 8'h00);           // hold
    rd(A_D0, v1);
    repeat (50) @(negedge clk);
    rd(A_D0, v2);
    check(v1 > 0 && v2 == v1, "R7 hold keeps count", v2, v1);
    wr(A_D0, 8'h33);             // compare only
    rd(A_D0, v3);
    check(v3 == v1, "R5 data write leaves count", v3, v1);
    wr(A_D0, 8'hFF);
    wr(A_MODE, 8'h04);           // keep: resume without clear
    repeat (40) @(negedge clk);
    rd(A_D0, v4);
    check(v4 >= v1 + 9 && v4 <= v1 + 12, "R7 resume from held", v4, v1 + 10);
    wr(A_MODE, 8'h08);           // go: clear
    rd(A_D0, v4);
    check(v4 == 0, "R6 go clears", v4, 0);
    wr(A_MODE, 8'h00);
    wr(A_D1, 8'hFF);
    wr(A_MODE, 8'h50);           // t1 go, src 1
    repeat (30) @(negedge clk);
    wr(A_MODE, 8'h00);
    rd(A_D1, v1);
    repeat (30) @(negedge clk);
    rd(A_D1, v2);
    check(v1 > 0 && v2 == v1, "R7 timer1 hold", v2, v1);
    check(v1 > 0, "R5 timer1 count read", v1, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_modereg();
    t_t0(0, 9, 4);
    t_t0(1, 4, 16);
    t_t0(2, 1, 64);
    t_t0(3, 1, 256);
    t_t1(1, 5, 4);
    t_t1(2, 2, 16);
    t_t1(3, 1, 64);
    t_cascade();
    t_zero_cmp();
    t_hold_and_data();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule